// File: doc/BRIEF.md
# Two-Bank DRAM Byte Steering Controller

This block connects an 8-bit processor bus to a pair of byte-wide DRAM banks. Together the two banks hold 16-bit words: bank 0 stores the even bytes and bank 1 stores the odd bytes. Each bank holds 256K bytes, which gives a 19-bit physical byte address, already translated upstream.

A pulse on `cyc_go` while the block is idle starts a fixed-length access. The block decodes the logical CPU address into a 3-bit device select code for an external decoder. It drives the 9-bit multiplexed DRAM address, with the row under RAS* and the column under CAS*. On a write it enables only the bank that holds the addressed byte. Every access reads both banks at once:

- Bank 0 passes straight through to `bus_data` while CAS* is low.
- Bank 1 is captured as CAS* rises and is shown on `bus_data` while CAS* is high.
- Address bit 0 chooses which of the two bytes is returned on `rd_data`.

When no valid bus cycle is in progress, the block treats the address as FFFF.

Top module: `dram_byte_steer`

## Requirements
- R1: The select code is 111 (RAM) for addresses 0000-7FFF, 000 (ROM) for 8000-BFFF and FF60-FFFF, 001 (cartridge) for C000-FEFF, 010 for FF00-FF0F and FF20-FF2F, and 011 for FF10-FF1F and FF30-FF3F. Code 101 is never produced.
- R2: For FF40-FF5F the select code is 100 when `int_disk_sel` is 1 and 110 when it is 0.
- R3: The address FFFF is decoded, giving 000, in two cases: while the block is idle, and during a cycle whose `cyc_valid` was 0 at start. In both cases no write enable is asserted.
- R4: An accepted cycle drops RAS* on the next clock. CAS* falls T_RCD (default 2) clocks later. CAS* stays low for T_CASL (2) clocks and high for T_CASH (2) clocks, during which RAS* is also high.
- R5: `dram_a` carries the row phys[18:10] while RAS* is low and CAS* is high. It carries the column phys[9:1] from CAS* fall to the end of the cycle, and 0 when idle.
- R6: A valid RAM write drives `we_n[0]` low for an even phys address, or `we_n[1]` low for an odd one, only while CAS* is low. Never both are low at once.
- R7: Both write enables stay high during reset, on reads, and for any select code other than 111.
- R8: While CAS* is low, `bus_data` equals `dq0_in`. While CAS* is high, it shows the `dq1_in` byte captured at the last CAS* rising edge (0 after reset).
- R9: From the CAS* rise onward, `rd_data` holds the byte at phys: `dq0_in` if phys[0]=0, `dq1_in` if phys[0]=1.
- R10: `busy` is high for the T_RCD+T_CASL+T_CASH clocks of a cycle. `done` pulses in the last of them. `cyc_go` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| int_disk_sel | input | 1 | Chooses the internal disk select code |
| cyc_go | input | 1 | Start request for a bus cycle |
| cyc_valid | input | 1 | The CPU is driving a real cycle |
| cyc_we | input | 1 | Write cycle |
| cyc_addr | input | 16 | Logical CPU address used for decode |
| cyc_phys | input | 19 | Physical byte address into the DRAM |
| dq0_in | input | 8 | Read data from bank 0 (even bytes) |
| dq1_in | input | 8 | Read data from bank 1 (odd bytes) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_a | output | 9 | Multiplexed row/column address |
| we_n | output | 2 | Per-bank write enables, active low |
| sel_code | output | 3 | Encoded device select |
| bus_data | output | 8 | Phase-steered read byte |
| rd_data | output | 8 | Byte returned to the CPU |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last clock of the cycle |

## Verification
The bench targets several corner cases, each with a visible symptom:

- **Odd versus even writes.** A swapped bank choice would corrupt the neighbouring byte of the word.
- **Writes outside RAM.** A write enable escaping on a ROM, I/O or disk write would trash memory.
- **Invalid bus cycles.** A write enable during a cycle with `cyc_valid` low would corrupt memory.
- **Disk decode option.** Flipping the option flips the disk code between 100 and 110.
- **Late bank 1 capture.** The bench drives junk on the data pins whenever CAS* is high. A latch taken after the CAS* rise would therefore return junk instead of the odd byte.
- **Start requests while busy.** `cyc_go` is held high across whole cycles. A controller that restarted mid-cycle would break the fixed strobe timing.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int CPU_AW  = 16;
    localparam int DRAM_AW = 9;
    localparam int PHYS_AW = 2 * DRAM_AW + 1;
    localparam int DW      = 8;
    localparam int NBANK   = 2;

    typedef enum logic [2:0] {
        SEL_ROM     = 3'b000,
        SEL_CART    = 3'b001,
        SEL_IO_LO   = 3'b010,
        SEL_IO_HI   = 3'b011,
        SEL_DSK_INT = 3'b100,
        SEL_UNUSED  = 3'b101,
        SEL_DSK_EXT = 3'b110,
        SEL_RAM     = 3'b111
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_RCD, PH_CASL, PH_CASH
    } phase_e;

    typedef struct packed {
        logic               valid;
        logic               we;
        logic [CPU_AW-1:0]  addr;
        logic [PHYS_AW-1:0] phys;
    } req_t;

    localparam logic [CPU_AW-1:0] IDLE_ADDR = '1;

    function automatic sel_e sel_of(input logic [CPU_AW-1:0] a, input logic int_dsk);
        sel_e s;
        if (a < 16'h8000)                  s = SEL_RAM;
        else if (a < 16'hC000)             s = SEL_ROM;
        else if (a < 16'hFF00)             s = SEL_CART;
        else if (a < 16'hFF40)             s = a[4] ? SEL_IO_HI : SEL_IO_LO;
        else if (a < 16'hFF60)             s = int_dsk ? SEL_DSK_INT : SEL_DSK_EXT;
        else                               s = SEL_ROM;
        return s;
    endfunction

    function automatic logic [DRAM_AW-1:0] row_of(input logic [PHYS_AW-1:0] p);
        return p[PHYS_AW-1 -: DRAM_AW];
    endfunction

    function automatic logic [DRAM_AW-1:0] col_of(input logic [PHYS_AW-1:0] p);
        return p[DRAM_AW:1];
    endfunction
endpackage

// File: rtl/dbs_sel_decode.sv
module dbs_sel_decode
    import dbs_pkg::*;
(
    input  logic              active,
    input  req_t              req,
    input  logic              int_disk_sel,
    output logic [2:0]        sel_code,
    output logic              ram_sel
);
    logic [CPU_AW-1:0] eff_addr;
    sel_e              sel;

    always_comb begin
        eff_addr = (active && req.valid) ? req.addr : IDLE_ADDR;
        sel      = sel_of(eff_addr, int_disk_sel);
        sel_code = sel;
        ram_sel  = (sel == SEL_RAM);
    end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
    import dbs_pkg::*;
#(
    parameter int T_RCD  = 2,
    parameter int T_CASL = 2,
    parameter int T_CASH = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [DRAM_AW-1:0] row,
    input  logic [DRAM_AW-1:0] col,
    input  logic               bank_odd,
    input  logic               wr_ok,
    output logic               ras_n,
    output logic               cas_n,
    output logic [DRAM_AW-1:0] dram_a,
    output logic [NBANK-1:0]   we_n,
    output logic               busy,
    output logic               accept,
    output logic               done,
    output logic               cap_en
);
    localparam int T_MAX0 = (T_RCD > T_CASL) ? T_RCD : T_CASL;
    localparam int T_MAX  = (T_MAX0 > T_CASH) ? T_MAX0 : T_CASH;
    localparam int CW     = $clog2(T_MAX) + 1;

    phase_e        state, state_nx;
    logic [CW-1:0] cnt;
    logic          last;

    always_comb begin
        case (state)
            PH_RCD:  last = (cnt == CW'(T_RCD - 1));
            PH_CASL: last = (cnt == CW'(T_CASL - 1));
            PH_CASH: last = (cnt == CW'(T_CASH - 1));
            default: last = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        case (state)
            PH_IDLE: if (go)   state_nx = PH_RCD;
            PH_RCD:  if (last) state_nx = PH_CASL;
            PH_CASL: if (last) state_nx = PH_CASH;
            PH_CASH: if (last) state_nx = PH_IDLE;
            default:           state_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        busy   = (state != PH_IDLE);
        accept = go && (state == PH_IDLE);
        done   = (state == PH_CASH) && last;
        cap_en = (state == PH_CASL) && last;
        ras_n  = !((state == PH_RCD) || (state == PH_CASL));
        cas_n  = (state != PH_CASL);
        case (state)
            PH_RCD:           dram_a = row;
            PH_CASL, PH_CASH: dram_a = col;
            default:          dram_a = '0;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_we
        assign we_n[b] = !((state == PH_CASL) && wr_ok && (bank_odd == b[0]));
    end
endmodule

// File: rtl/dbs_rd_steer.sv
module dbs_rd_steer
    import dbs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic          cas_n,
    input  logic          bank_odd,
    input  logic [DW-1:0] dq0_in,
    input  logic [DW-1:0] dq1_in,
    output logic [DW-1:0] bus_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] odd_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            odd_lat <= '0;
            rd_data <= '0;
        end else if (cap_en) begin
            odd_lat <= dq1_in;
            rd_data <= bank_odd ? dq1_in : dq0_in;
        end
    end

    assign bus_data = cas_n ? odd_lat : dq0_in;
endmodule

// File: rtl/dram_byte_steer.sv
module dram_byte_steer
    import dbs_pkg::*;
#(
    parameter int T_RCD  = 2,
    parameter int T_CASL = 2,
    parameter int T_CASH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         int_disk_sel,
    input  logic         cyc_go,
    input  logic         cyc_valid,
    input  logic         cyc_we,
    input  logic [15:0]  cyc_addr,
    input  logic [18:0]  cyc_phys,
    input  logic [7:0]   dq0_in,
    input  logic [7:0]   dq1_in,
    output logic         ras_n,
    output logic         cas_n,
    output logic [8:0]   dram_a,
    output logic [1:0]   we_n,
    output logic [2:0]   sel_code,
    output logic [7:0]   bus_data,
    output logic [7:0]   rd_data,
    output logic         busy,
    output logic         done
);
    req_t req_q;
    logic accept, cap_en, ram_sel, wr_ok;

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= '{valid: cyc_valid, we: cyc_we, addr: cyc_addr, phys: cyc_phys};
    end

    dbs_sel_decode u_dec (
        .active       (busy),
        .req          (req_q),
        .int_disk_sel (int_disk_sel),
        .sel_code     (sel_code),
        .ram_sel      (ram_sel)
    );

    assign wr_ok = req_q.valid && req_q.we && ram_sel;

    dbs_seq #(.T_RCD(T_RCD), .T_CASL(T_CASL), .T_CASH(T_CASH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (cyc_go),
        .row      (row_of(req_q.phys)),
        .col      (col_of(req_q.phys)),
        .bank_odd (req_q.phys[0]),
        .wr_ok    (wr_ok),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .dram_a   (dram_a),
        .we_n     (we_n),
        .busy     (busy),
        .accept   (accept),
        .done     (done),
        .cap_en   (cap_en)
    );

    dbs_rd_steer u_rd (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cas_n    (cas_n),
        .bank_odd (req_q.phys[0]),
        .dq0_in   (dq0_in),
        .dq1_in   (dq1_in),
        .bus_data (bus_data),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/dram_byte_steer_chk.sv
module dram_byte_steer_chk (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cas_n,
    input logic [8:0] dram_a,
    input logic [1:0] we_n,
    input logic [2:0] sel_code,
    input logic [7:0] bus_data
);
    assert_ras_before_cas_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (!ras_n && $past(!ras_n)));

    assert_col_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_a));

    assert_one_bank_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(~we_n) <= 1);

    assert_we_in_cas_R6: assert property (@(posedge clk) disable iff (rst)
        (we_n != 2'b11) |-> !cas_n);

    assert_we_ram_only_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_code != 3'b111) |-> (we_n == 2'b11));

    assert_no_code_five_R1: assert property (@(posedge clk) disable iff (rst)
        sel_code != 3'b101);

    assert_latch_held_R8: assert property (@(posedge clk) disable iff (rst)
        (cas_n && $past(cas_n)) |-> $stable(bus_data));
endmodule

bind dram_byte_steer dram_byte_steer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dram_a   (dram_a),
    .we_n     (we_n),
    .sel_code (sel_code),
    .bus_data (bus_data)
);

// File: tb/sim_dram_byte_steer.sv
module sim_dram_byte_steer;
    localparam int RCD = 2, CL = 2, CH = 2, NCYC = RCD + CL + CH;

    logic clk = 1'b0, rst = 1'b1;
    logic int_disk_sel = 1'b0, cyc_go = 1'b0, cyc_valid = 1'b0, cyc_we = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic [18:0] cyc_phys = '0;
    logic [7:0]  dq0_in, dq1_in, bus_data, rd_data;
    logic ras_n, cas_n, busy, done;
    logic [8:0] dram_a, row_q = '0;
    logic [1:0] we_n;
    logic [2:0] sel_code;

    int errors = 0, checks = 0, cycles = 0;

    always #4 clk = ~clk;

    dram_byte_steer u0 (.*);

    function automatic logic [7:0] memf(input logic [18:0] p);
        return p[7:0] ^ p[15:8] ^ {5'b0, p[18:16]} ^ 8'h3C;
    endfunction

    function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic dsk);
        if (a <= 16'h7FFF) return 3'b111;
        if (a <= 16'hBFFF) return 3'b000;
        if (a <= 16'hFEFF) return 3'b001;
        if ((a >= 16'hFF00 && a <= 16'hFF0F) || (a >= 16'hFF20 && a <= 16'hFF2F)) return 3'b010;
        if ((a >= 16'hFF10 && a <= 16'hFF1F) || (a >= 16'hFF30 && a <= 16'hFF3F)) return 3'b011;
        if (a >= 16'hFF40 && a <= 16'hFF5F) return dsk ? 3'b100 : 3'b110;
        return 3'b000;
    endfunction

    // DRAM model: row taken while RAS low and CAS high; junk when CAS high
    always @(negedge clk) if (!ras_n && cas_n) row_q <= dram_a;
    assign dq0_in = cas_n ? 8'hEE : memf({row_q, dram_a, 1'b0});
    assign dq1_in = cas_n ? 8'hEE : memf({row_q, dram_a, 1'b1});

    // behavioural reference
    int m_busy = 0, m_t = 0;
    logic m_v = 0, m_we = 0;
    logic [15:0] m_addr = '0;
    logic [18:0] m_phys = '0;
    logic [7:0] m_lat = '0, m_rd = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_t <= 0; m_v <= 0; m_lat <= '0; m_rd <= '0;
        end else if (m_busy != 0) begin
            if (m_t == RCD + CL) begin
                m_lat <= memf({m_phys[18:1], 1'b1});
                m_rd  <= memf(m_phys);
            end
            if (m_t == NCYC) m_busy <= 0;
            else m_t <= m_t + 1;
        end else if (cyc_go) begin
            m_busy <= 1; m_t <= 1;
            m_v <= cyc_valid; m_we <= cyc_we; m_addr <= cyc_addr; m_phys <= cyc_phys;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [2:0] esel;
        logic [1:0] ewe;
        logic       rl, cl;
        #3;
        cycles++;
        rl = (m_busy != 0) && (m_t <= RCD + CL);
        cl = (m_busy != 0) && (m_t > RCD) && (m_t <= RCD + CL);
        esel = (m_busy != 0 && m_v) ? exp_sel(m_addr, int_disk_sel) : 3'b000;   // R3 idle/invalid -> FFFF
        ewe = 2'b11;
        if (!rst && cl && m_v && m_we && esel == 3'b111) ewe[m_phys[0]] = 1'b0;
        check(esel[2:1] == 2'b10 ? "R2 disk select" : "R1 select code", sel_code, esel);
        check("R7/R6 write enables", we_n, ewe);
        check("R4 ras_n", ras_n, !rl);
        check("R4 cas_n", cas_n, !cl);
        if (m_busy == 0)       check("R5 idle address", dram_a, 9'd0);
        else if (m_t <= RCD)   check("R5 row address", dram_a, m_phys[18:10]);
        else                   check("R5 column address", dram_a, m_phys[9:1]);
        if (cl) check("R8 pass-through byte", bus_data, memf({m_phys[18:1], 1'b0}));
        else    check("R8 latched byte", bus_data, m_lat);
        check("R9 rd_data", rd_data, m_rd);
        check("R10 busy", busy, m_busy != 0);
        check("R10 done", done, (m_busy != 0) && m_t == NCYC);
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cyc(input logic v, input logic w, input logic [15:0] a, input logic [18:0] p);
        @(negedge clk);
        cyc_go = 1; cyc_valid = v; cyc_we = w; cyc_addr = a; cyc_phys = p;
        @(negedge clk);
        cyc_go = 0;
        repeat (NCYC + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R7, R3, R10)
        check("R7 reset we_n", we_n, 2'b11);
        check("R3 reset sel", sel_code, 3'b000);
        check("R10 reset busy", busy, 1'b0);
        rst = 0;
        cyc(1, 1, 16'h1234, 19'h2A5C4);   // R6 even write
        cyc(1, 1, 16'h1235, 19'h2A5C5);   // R6 odd write
        cyc(1, 0, 16'h0100, 19'h7FFFE);   // R9 even read
        cyc(1, 0, 16'h0101, 19'h40001);   // R9 odd read, R8
        cyc(1, 1, 16'h9000, 19'h00010);   // R7 ROM write blocked
        cyc(1, 1, 16'hD000, 19'h00011);   // R1 cartridge
        cyc(1, 1, 16'hFF03, 19'h00020);   // R1 io low
        cyc(1, 0, 16'hFF34, 19'h00021);   // R1 io high
        cyc(1, 1, 16'hFF48, 19'h00030);   // R2 external disk
        int_disk_sel = 1;
        cyc(1, 1, 16'hFF48, 19'h00031);   // R2 internal disk
        cyc(1, 0, 16'hFFFE, 19'h00032);   // R1 vectors ROM
        cyc(0, 1, 16'h0010, 19'h12345);   // R3 invalid cycle, no write
        // R10 go held high across cycles, random traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cyc_go = ($urandom_range(0, 3) != 0);
            cyc_valid = ($urandom_range(0, 7) != 0);
            cyc_we = $urandom_range(0, 1);
            cyc_addr = $urandom_range(0, 1) ? 16'($urandom) : 16'hFF00 | 16'($urandom_range(0, 127));
            cyc_phys = 19'($urandom);
            if (i % 500 == 0) int_disk_sel = ~int_disk_sel;
        end
        @(negedge clk);
        cyc_go = 0;
        repeat (NCYC + 2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule